// File: doc/BRIEF.md
# Set-Associative Data Cache Timing Model

This block models how a small data cache hits, misses and stalls, without holding any data. For each line it keeps a valid bit, a dirty bit and a tag, and for each set it keeps a round-robin victim pointer. A pipeline presents one load or store at a time, with its byte address. One cycle later the block answers with the number of cycles the requester must stall. The cost comes from separate read and write latencies of the next memory level.

The cache is write-back and write-allocate, with no write buffer. A store miss therefore pays the full fetch before it completes, and evicting a dirty line adds a full write before that fetch. A bypass mode turns caching off, so every access pays its raw memory cost. At the end of a run, a drain command walks every line and writes back the dirty ones. Each of those counts as a writeback, but none of them is charged as a stall. Counters report accesses, misses and writebacks, with accesses and misses split into loads and stores.

Top module: `dcache_timing_model`

## Requirements
- R1: After reset every line is invalid and every counter reads zero. `resp_valid` and `drain_busy` are low.
- R2: A byte address splits into three fields: bits [4:0] are the offset within a 32-byte block, bits [7:5] select one of 8 sets, and bits [31:8] form the tag. Two addresses that differ only in the offset hit the same line. The same tag in a different set is a separate line.
- R3: With caching on, a load hit returns a stall of 0. A load miss whose victim is invalid or clean returns a stall of 30.
- R4: A store hit returns a stall of 0 and marks the line dirty. A store miss allocates the line, returns a stall of 30 and leaves the line dirty.
- R5: A miss, load or store, whose victim line is valid and dirty returns a stall of 40 and adds one to the writeback counter.
- R6: Each of the 4 ways in a set is chosen by a per-set pointer. The pointer starts at way 0 and advances by one, wrapping, on every allocation. Hits do not move it, and the victim is always the way it names, regardless of recent use.
- R7: An accepted request yields `resp_valid` high for exactly the next cycle, with `resp_stall` holding that request's cost.
- R8: Every accepted request adds one to the access counter and one to either the load or the store counter. Every miss adds one to the miss counter and one to either the load-miss or the store-miss counter. A store is flagged by `req_write` = 1.
- R9: With `cache_en` low, a load returns 30 and a store returns 10. Each is counted as an access and as a miss. Tags, valid bits, dirty bits and pointers are left unchanged.
- R10: A `drain_start` pulse keeps `drain_busy` high for 32 cycles, one per line. Each valid dirty line is made clean and counted as a writeback, and no response is produced. A later eviction of a drained line costs 30.
- R11: Requests presented while `drain_busy` is high are ignored. They produce no response and change no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_en | input | 1 | 1 = caching on, 0 = bypass to memory |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address of the access |
| drain_start | input | 1 | Pulse to start writing back all dirty lines |
| resp_valid | output | 1 | Stall value for the previous request is valid |
| resp_stall | output | 8 | Stall cycles charged to that request |
| drain_busy | output | 1 | Drain walk in progress |
| cnt_access | output | 32 | Total accepted requests |
| cnt_load | output | 32 | Accepted loads |
| cnt_store | output | 32 | Accepted stores |
| cnt_miss | output | 32 | Total misses |
| cnt_load_miss | output | 32 | Load misses |
| cnt_store_miss | output | 32 | Store misses |
| cnt_writeback | output | 32 | Dirty lines written back |

## Verification
The bench fills one set past its four ways, then touches a resident line before the next miss. A design that replaced by recency instead of by pointer would evict a different way, and the miss pattern that follows would show it. Dirty evictions are driven from both a load and a store. A design that forgot the write cost, or that marked a store miss clean, would return 30 where 40 is due, or would report the wrong writeback count. Bypass accesses are aimed at a resident line and at a new block. A design that allocated or dirtied lines in bypass mode would turn a later hit into a miss, or would add writebacks at drain time. The drain is checked for its length, its writeback total and the clean state it leaves behind. Requests made during the drain must change no counter.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
    // Outcome of one accepted request, as seen by the statistics unit
    typedef struct packed {
        logic valid;
        logic write;
        logic miss;
    } acc_event_t;
endpackage

// File: rtl/dcache_lookup.sv
module dcache_lookup #(
    parameter int NUM_WAYS = 4,
    parameter int TAG_W    = 24,
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic [NUM_WAYS-1:0]              valid_i,
    input  logic [NUM_WAYS-1:0][TAG_W-1:0]   tags_i,
    input  logic [TAG_W-1:0]                 tag_i,
    output logic                             hit_o,
    output logic [WAY_W-1:0]                 hit_way_o
);
    logic [NUM_WAYS-1:0] match;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        assign match[w] = valid_i[w] && (tags_i[w] == tag_i);
    end

    always_comb begin
        hit_way_o = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (match[w]) hit_way_o = WAY_W'(w);
        end
    end

    assign hit_o = |match;

    // A block may live in at most one way of its set
    assert_single_hit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(match));
endmodule

// File: rtl/dcache_stats.sv
module dcache_stats
    import dcache_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  acc_event_t       ev_i,
    input  logic             wb_i,
    output logic [CNT_W-1:0] access_o,
    output logic [CNT_W-1:0] load_o,
    output logic [CNT_W-1:0] store_o,
    output logic [CNT_W-1:0] miss_o,
    output logic [CNT_W-1:0] load_miss_o,
    output logic [CNT_W-1:0] store_miss_o,
    output logic [CNT_W-1:0] wb_o
);
    typedef struct packed {
        logic [CNT_W-1:0] access;
        logic [CNT_W-1:0] load;
        logic [CNT_W-1:0] store;
        logic [CNT_W-1:0] miss;
        logic [CNT_W-1:0] load_miss;
        logic [CNT_W-1:0] store_miss;
        logic [CNT_W-1:0] wb;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (ev_i.valid) begin
            cnt_d.access = cnt_q.access + 1'b1;
            if (ev_i.write) cnt_d.store = cnt_q.store + 1'b1;
            else            cnt_d.load  = cnt_q.load + 1'b1;
            if (ev_i.miss) begin
                cnt_d.miss = cnt_q.miss + 1'b1;
                if (ev_i.write) cnt_d.store_miss = cnt_q.store_miss + 1'b1;
                else            cnt_d.load_miss  = cnt_q.load_miss + 1'b1;
            end
        end
        if (wb_i) cnt_d.wb = cnt_q.wb + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign access_o     = cnt_q.access;
    assign load_o       = cnt_q.load;
    assign store_o      = cnt_q.store;
    assign miss_o       = cnt_q.miss;
    assign load_miss_o  = cnt_q.load_miss;
    assign store_miss_o = cnt_q.store_miss;
    assign wb_o         = cnt_q.wb;

    assert_access_split_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q.access == cnt_q.load + cnt_q.store);
    assert_miss_split_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q.miss == cnt_q.load_miss + cnt_q.store_miss);
    assert_miss_le_access_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q.miss <= cnt_q.access);
    assert_wb_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q.wb == $past(cnt_q.wb)) || (cnt_q.wb == $past(cnt_q.wb) + 1'b1));
endmodule

// File: rtl/dcache_timing_model.sv
module dcache_timing_model
    import dcache_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int BLOCK_BYTES = 32,
    parameter int NUM_SETS    = 8,
    parameter int NUM_WAYS    = 4,
    parameter int READ_LAT    = 30,
    parameter int WRITE_LAT   = 10,
    parameter int STALL_W     = 8,
    parameter int CNT_W       = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cache_en,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               drain_start,
    output logic               resp_valid,
    output logic [STALL_W-1:0] resp_stall,
    output logic               drain_busy,
    output logic [CNT_W-1:0]   cnt_access,
    output logic [CNT_W-1:0]   cnt_load,
    output logic [CNT_W-1:0]   cnt_store,
    output logic [CNT_W-1:0]   cnt_miss,
    output logic [CNT_W-1:0]   cnt_load_miss,
    output logic [CNT_W-1:0]   cnt_store_miss,
    output logic [CNT_W-1:0]   cnt_writeback
);
    localparam int OFFS_W = $clog2(BLOCK_BYTES);
    localparam int IDX_W  = $clog2(NUM_SETS);
    localparam int WAY_W  = $clog2(NUM_WAYS);
    localparam int TAG_W  = ADDR_W - OFFS_W - IDX_W;
    localparam int LINES  = NUM_SETS * NUM_WAYS;
    localparam int LINE_W = $clog2(LINES);
    localparam logic [STALL_W-1:0] RD_COST = STALL_W'(READ_LAT);
    localparam logic [STALL_W-1:0] WR_COST = STALL_W'(WRITE_LAT);
    localparam logic [LINE_W-1:0]  LAST_LINE = LINE_W'(LINES - 1);

    typedef struct packed {
        logic [NUM_SETS-1:0][NUM_WAYS-1:0]            valid;
        logic [NUM_SETS-1:0][NUM_WAYS-1:0]            dirty;
        logic [NUM_SETS-1:0][NUM_WAYS-1:0][TAG_W-1:0] tag;
        logic [NUM_SETS-1:0][WAY_W-1:0]               ptr;
        logic                                         busy;
        logic [LINE_W-1:0]                            idx;
        logic                                         resp_valid;
        logic [STALL_W-1:0]                           resp_stall;
    } state_t;

    state_t state_d, state_q;

    logic [IDX_W-1:0]  req_set;
    logic [TAG_W-1:0]  req_tag;
    logic              hit;
    logic [WAY_W-1:0]  hit_way;
    logic [WAY_W-1:0]  victim;
    logic              victim_dirty;
    logic [IDX_W-1:0]  drn_set;
    logic [WAY_W-1:0]  drn_way;
    acc_event_t        ev;
    logic              wb_pulse;

    assign req_set = req_addr[OFFS_W +: IDX_W];
    assign req_tag = req_addr[ADDR_W-1 -: TAG_W];
    assign drn_set = state_q.idx[LINE_W-1:WAY_W];
    assign drn_way = state_q.idx[WAY_W-1:0];

    dcache_lookup #(
        .NUM_WAYS (NUM_WAYS),
        .TAG_W    (TAG_W)
    ) i_lookup (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .valid_i   (state_q.valid[req_set]),
        .tags_i    (state_q.tag[req_set]),
        .tag_i     (req_tag),
        .hit_o     (hit),
        .hit_way_o (hit_way)
    );

    assign victim       = state_q.ptr[req_set];
    assign victim_dirty = state_q.valid[req_set][victim] && state_q.dirty[req_set][victim];

    always_comb begin
        state_d            = state_q;
        state_d.resp_valid = 1'b0;
        state_d.resp_stall = '0;
        ev                 = '{valid: 1'b0, write: req_write, miss: 1'b0};
        wb_pulse           = 1'b0;

        if (state_q.busy) begin
            // One line per cycle; requests are not accepted meanwhile
            if (state_q.valid[drn_set][drn_way] && state_q.dirty[drn_set][drn_way]) begin
                state_d.dirty[drn_set][drn_way] = 1'b0;
                wb_pulse = 1'b1;
            end
            if (state_q.idx == LAST_LINE) state_d.busy = 1'b0;
            else                          state_d.idx  = state_q.idx + 1'b1;
        end else if (drain_start) begin
            state_d.busy = 1'b1;
            state_d.idx  = '0;
        end else if (req_valid) begin
            state_d.resp_valid = 1'b1;
            ev.valid           = 1'b1;
            if (!cache_en) begin
                ev.miss            = 1'b1;
                state_d.resp_stall = req_write ? WR_COST : RD_COST;
            end else if (hit) begin
                if (req_write) state_d.dirty[req_set][hit_way] = 1'b1;
            end else begin
                ev.miss                          = 1'b1;
                wb_pulse                         = victim_dirty;
                state_d.resp_stall               = victim_dirty ? RD_COST + WR_COST : RD_COST;
                state_d.valid[req_set][victim]   = 1'b1;
                state_d.dirty[req_set][victim]   = req_write;
                state_d.tag[req_set][victim]     = req_tag;
                state_d.ptr[req_set]             = victim + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    dcache_stats #(
        .CNT_W (CNT_W)
    ) i_stats (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .ev_i         (ev),
        .wb_i         (wb_pulse),
        .access_o     (cnt_access),
        .load_o       (cnt_load),
        .store_o      (cnt_store),
        .miss_o       (cnt_miss),
        .load_miss_o  (cnt_load_miss),
        .store_miss_o (cnt_store_miss),
        .wb_o         (cnt_writeback)
    );

    assign resp_valid = state_q.resp_valid;
    assign resp_stall = state_q.resp_stall;
    assign drain_busy = state_q.busy;

    // Only the four legal costs can ever be reported
    assert_stall_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_stall == '0 || resp_stall == RD_COST ||
                        resp_stall == WR_COST || resp_stall == RD_COST + WR_COST));
    // The drain walk never produces a response
    assert_drain_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        drain_busy |=> !resp_valid);
    // A response is never held for two cycles
    assert_resp_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> (!resp_valid || $past(req_valid)));
    // Counters hold still while the drain runs
    assert_drain_no_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
        drain_busy |=> $stable(cnt_access));
endmodule

// File: tb/test_dcache_timing_model.sv
module test_dcache_timing_model;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cache_en = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic        drain_start = 1'b0;
    logic        resp_valid;
    logic [7:0]  resp_stall;
    logic        drain_busy;
    logic [31:0] cnt_access, cnt_load, cnt_store, cnt_miss;
    logic [31:0] cnt_load_miss, cnt_store_miss, cnt_writeback;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dcache_timing_model i_dcache_timing_model (
        .clk            (clk),
        .rst_n          (rst_n),
        .cache_en       (cache_en),
        .req_valid      (req_valid),
        .req_write      (req_write),
        .req_addr       (req_addr),
        .drain_start    (drain_start),
        .resp_valid     (resp_valid),
        .resp_stall     (resp_stall),
        .drain_busy     (drain_busy),
        .cnt_access     (cnt_access),
        .cnt_load       (cnt_load),
        .cnt_store      (cnt_store),
        .cnt_miss       (cnt_miss),
        .cnt_load_miss  (cnt_load_miss),
        .cnt_store_miss (cnt_store_miss),
        .cnt_writeback  (cnt_writeback)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(int tag, int set, int off);
        return {tag[23:0], set[2:0], off[4:0]};
    endfunction

    task automatic acc(logic [31:0] addr, logic wr, int exp_stall, string req);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = addr;
        req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req, "resp_valid", {31'b0, resp_valid}, 32'd1);
        chk(req, "resp_stall", {24'b0, resp_stall}, exp_stall);
    endtask

    task automatic chk_counts(string req, int a, int l, int s, int m, int lm, int sm, int wb);
        chk(req, "accesses", cnt_access, a);
        chk(req, "loads", cnt_load, l);
        chk(req, "stores", cnt_store, s);
        chk(req, "misses", cnt_miss, m);
        chk(req, "load misses", cnt_load_miss, lm);
        chk(req, "store misses", cnt_store_miss, sm);
        chk(req, "writebacks", cnt_writeback, wb);
    endtask

    task automatic t_reset();
        chk("R1", "resp_valid", {31'b0, resp_valid}, 0);
        chk("R1", "drain_busy", {31'b0, drain_busy}, 0);
        chk_counts("R1", 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk("R7", "idle resp_valid", {31'b0, resp_valid}, 0);
    endtask

    task automatic t_basic();
        acc(mk(1, 0, 0), 1'b0, 30, "R3");   // cold load miss
        @(negedge clk);
        chk("R7", "response lasts one cycle", {31'b0, resp_valid}, 0);
        acc(mk(1, 0, 4), 1'b0, 0, "R2");    // same block, other offset
        acc(mk(1, 1, 0), 1'b0, 30, "R2");   // same tag, other set
        acc(mk(1, 0, 8), 1'b1, 0, "R4");    // store hit, now dirty
        acc(mk(2, 2, 0), 1'b1, 30, "R4");   // store miss allocates dirty
    endtask

    task automatic t_round_robin();
        acc(mk(3, 0, 0), 1'b0, 30, "R6");
        acc(mk(4, 0, 0), 1'b0, 30, "R6");
        acc(mk(5, 0, 0), 1'b0, 30, "R6");
        acc(mk(1, 0, 0), 1'b0, 0,  "R6");   // hit, pointer stays on way 0
        acc(mk(6, 0, 0), 1'b0, 40, "R5");   // evicts dirty way 0
        acc(mk(1, 0, 0), 1'b0, 30, "R6");   // evicts way 1 (tag 3)
        acc(mk(4, 0, 0), 1'b0, 0,  "R6");   // recent use of way 2
        acc(mk(3, 0, 0), 1'b0, 30, "R6");   // still evicts way 2 (tag 4)
        acc(mk(4, 0, 0), 1'b0, 30, "R6");   // tag 4 gone, evicts way 3
        acc(mk(5, 0, 0), 1'b0, 30, "R6");   // evicts way 0 (clean tag 6)
        chk_counts("R8", 15, 13, 2, 11, 10, 1, 1);
    endtask

    task automatic t_store_evict();
        acc(mk(1, 1, 0), 1'b1, 0,  "R4");
        acc(mk(7, 1, 0), 1'b1, 30, "R4");
        acc(mk(8, 1, 0), 1'b1, 30, "R4");
        acc(mk(9, 1, 0), 1'b1, 30, "R4");
        acc(mk(10, 1, 0), 1'b1, 40, "R5");  // store miss over dirty way 0
        chk("R5", "writebacks", cnt_writeback, 2);
        chk_counts("R8", 20, 13, 7, 15, 10, 5, 2);
    endtask

    task automatic t_bypass();
        cache_en = 1'b0;
        acc(mk(5, 0, 0), 1'b0, 30, "R9");
        acc(mk(5, 0, 0), 1'b1, 10, "R9");
        acc(mk(20, 4, 0), 1'b0, 30, "R9");
        cache_en = 1'b1;
        acc(mk(5, 0, 0), 1'b0, 0,  "R9");   // still resident
        acc(mk(20, 4, 0), 1'b0, 30, "R9");  // never allocated
        chk_counts("R9", 25, 17, 8, 19, 13, 6, 2);
    endtask

    task automatic t_drain();
        int  busy_cycles = 0;
        bit  stray = 1'b0;
        @(negedge clk);
        drain_start = 1'b1;
        @(negedge clk);
        drain_start = 1'b0;
        while (drain_busy && busy_cycles < 100) begin
            if (resp_valid) stray = 1'b1;
            req_valid = (busy_cycles < 4);
            req_addr  = mk(30, 5, 0);
            req_write = 1'b0;
            busy_cycles++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk("R10", "busy cycles", busy_cycles, 32);
        chk("R11", "response during drain", {31'b0, stray}, 0);
        chk("R11", "accesses after drain", cnt_access, 25);
        chk("R10", "writebacks after drain", cnt_writeback, 7);
        acc(mk(11, 1, 0), 1'b0, 30, "R10"); // victim tag 7 is now clean
        chk("R10", "no writeback for clean victim", cnt_writeback, 7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_round_robin();
        t_store_evict();
        t_bypass();
        t_drain();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule